// File: doc/BRIEF.md
# Self-Timed Byte-Write Nonvolatile Memory Core

This block is a synthesizable behavioural model of a small byte-writable nonvolatile store that looks like a static RAM from the host side. Reads are combinational from the pins. A write is framed by the active-low chip-enable and write-enable strobes while output-enable is held high. After the strobes close, the byte is committed by an internal cycle timer. During that time the `ready` output is held low, and any read returns a polling pattern whose top bit is the inverse of the top bit being written.

The strobes and the address, data and high-voltage flags are passed together through one synchronizer, so the address and data stay aligned with the strobe edges they belong to. The host must hold the address and data stable for the synchronizer latency around the relevant strobe edge.

Writes are blocked in several cases:
- output-enable is low;
- supply-good is false;
- the supply has not yet been good for a power-on delay;
- a write is already in progress.

A long write-enable pulse with the erase flag raised sets the whole main array to ones. With the address-9 flag raised, the topmost 32 addresses reach a separate identification array.

There is no valid/ready handshake. Strobe edges frame each transfer, and `ready` is the only flow-control signal: a host wanting back-pressure waits for `ready` high before opening the next write.

Top module: `nvm_byte_core`

## Requirements
- R1: `data_oe` is 1 only while `ce_n`=0, `oe_n`=0 and `we_n`=1. Whenever `data_oe` is 0, `data_out` is all zeros.
- R2: A write window is open while `ce_n`=0, `we_n`=0 and `oe_n`=1. The address is taken when the window opens, which is the later of the two falling strobes. The data is taken when the window closes, which is the earlier of the two rising strobes.
- R3: A write starts when its window closes. `ready` is then 0 for exactly WR_CYC clock cycles, which is FAST_WR_CYC when FAST_SIM=1, and the byte is stored in the cycle `ready` returns to 1.
- R4: While `ready`=0, a driven read at any address returns bit 7 equal to the inverse of the pending byte's bit 7, and bits 6:0 equal to 0. From the cycle `ready` returns to 1, reads return the stored byte.
- R5: A window that closes because `oe_n` falls starts no write. No write starts while `supply_good`=0.
- R6: No write starts until `supply_good` has been 1 for POR_CYC consecutive cycles. Dropping `supply_good` restarts that count.
- R7: Strobe activity while a write is in progress is ignored and leaves no pending write behind.
- R8: With `a9_hv`=1, addresses whose bits 10:5 are all ones reach a separate 32-byte identification array, indexed by bits 4:0, for both reads and writes. With `a9_hv`=0, the same addresses reach the main array.
- R9: With `erase_hv`=1 and `ce_n`=0, a `we_n` low period of at least ERASE_CYC cycles sets every main-array byte to 8'hFF when `we_n` rises. A shorter period changes nothing, the identification array is untouched, and no ordinary write starts while `erase_hv`=1.
- R10: After reset, `ready` is 1 and every byte of both arrays reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the synchronizer and all timers |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| data_in | input | DATA_W | Write data |
| data_out | output | DATA_W | Read data, zero when not driven |
| data_oe | output | 1 | Read-data drive enable (tri-state control) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| ready | output | 1 | High when idle, low while a write is being timed |
| supply_good | input | 1 | Supply within write range |
| erase_hv | input | 1 | High-voltage flag for whole-array erase |
| a9_hv | input | 1 | High-voltage flag selecting the identification array |

## Verification
Two things can happen in the same clock edge: the internal commit of a pending byte and a host read of that byte. The bench provokes this by holding chip and output enable low through the end of a write, so the read is open both before and after the release. Each half-cycle sample is judged against `ready`: while `ready` is 0 the sample must carry the inverted-bit-7 polling pattern, and on the first sample with `ready` at 1 it must carry the true byte, never a stale one.

// File: rtl/nvm_core_pkg.sv
`timescale 1ns/1ps
package nvm_core_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ARMED = 2'd1,
    WS_BUSY  = 2'd2
  } wr_state_e;

  // Convert a duration in microseconds to clock cycles, minimum one.
  function automatic int unsigned us_to_cyc(input int unsigned clk_hz,
                                            input int unsigned us);
    longint unsigned c;
    c = (longint'(clk_hz) / 64'd1_000_000) * longint'(us);
    if (c == 0) c = 1;
    return c[31:0];
  endfunction

endpackage

// File: rtl/nvm_strobe_sync.sv
`timescale 1ns/1ps
module nvm_strobe_sync #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic [W-1:0] r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= g_stg[i-1].r;
      end
    end
  end

  assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/nvm_write_ctrl.sv
`timescale 1ns/1ps
module nvm_write_ctrl
  import nvm_core_pkg::*;
#(
  parameter int          ADDR_W    = 11,
  parameter int          DATA_W    = 8,
  parameter int          ID_DEPTH  = 32,
  parameter int unsigned WR_CYC    = 16,
  parameter int unsigned POR_CYC   = 16,
  parameter int unsigned ERASE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              oe_s,
  input  logic              we_s,
  input  logic              er_hv_s,
  input  logic              a9_hv_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  input  logic              supply_good,
  output logic              busy,
  output logic              cm_en,
  output logic              cm_id,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_data,
  output logic              clr_main,
  output logic              pend_msb
);

  localparam int ID_AW = $clog2(ID_DEPTH);
  localparam int WT_W  = $clog2(WR_CYC + 1);
  localparam int PC_W  = $clog2(POR_CYC + 1);
  localparam int EC_W  = $clog2(ERASE_CYC + 1);

  wr_state_e         state;
  logic [WT_W-1:0]   timer;
  logic [PC_W-1:0]   por_cnt;
  logic [EC_W-1:0]   er_cnt;
  logic              wr_q, er_q;
  logic              lat_id;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;

  logic wr_act, er_act, por_done, ok_wr, id_hit, er_long;

  assign wr_act   = !ce_s && !we_s && oe_s;
  assign er_act   = !ce_s && !we_s && er_hv_s;
  assign por_done = (por_cnt == PC_W'(POR_CYC));
  assign ok_wr    = supply_good && por_done && !er_hv_s;
  assign id_hit   = a9_hv_s && (&addr_s[ADDR_W-1:ID_AW]);
  assign er_long  = (er_cnt >= EC_W'(ERASE_CYC));

  assign busy     = (state == WS_BUSY);
  assign cm_en    = busy && (timer == WT_W'(WR_CYC - 1));
  assign cm_id    = lat_id;
  assign cm_addr  = lat_addr;
  assign cm_data  = lat_data;
  assign pend_msb = lat_data[DATA_W-1];
  assign clr_main = er_q && !er_act && er_long && supply_good
                    && por_done && !busy;

  // Power-on window and erase pulse length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_cnt <= '0;
      er_cnt  <= '0;
      er_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      wr_q <= wr_act;
      er_q <= er_act;
      if (!supply_good)  por_cnt <= '0;
      else if (!por_done) por_cnt <= por_cnt + 1'b1;
      if (er_act) begin
        if (!er_long) er_cnt <= er_cnt + 1'b1;
      end else begin
        er_cnt <= '0;
      end
    end
  end

  // Write sequencer: arm on window open, start on window close, time out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= WS_IDLE;
      timer    <= '0;
      lat_id   <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      unique case (state)
        WS_IDLE: begin
          if (wr_act && !wr_q && ok_wr) begin
            state    <= WS_ARMED;
            lat_addr <= addr_s;
            lat_id   <= id_hit;
          end
        end
        WS_ARMED: begin
          if (!ok_wr) begin
            state <= WS_IDLE;
          end else if (!wr_act) begin
            if (oe_s) begin
              state    <= WS_BUSY;
              lat_data <= din_s;
              timer    <= '0;
            end else begin
              state <= WS_IDLE;
            end
          end
        end
        WS_BUSY: begin
          if (timer == WT_W'(WR_CYC - 1)) state <= WS_IDLE;
          else                            timer <= timer + 1'b1;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nvm_cell_array.sv
`timescale 1ns/1ps
module nvm_cell_array #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int ID_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_id,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_main,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_id,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int ID_AW = $clog2(ID_DEPTH);

  logic [DATA_W-1:0] main_m [DEPTH];
  logic [DATA_W-1:0] id_m   [ID_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) main_m[i] <= '1;
    end else begin
      if (clr_main) begin
        for (int i = 0; i < DEPTH; i++) main_m[i] <= '1;
      end
      if (wr_en && !wr_id) main_m[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ID_DEPTH; i++) id_m[i] <= '1;
    end else if (wr_en && wr_id) begin
      id_m[wr_addr[ID_AW-1:0]] <= wr_data;
    end
  end

  assign rd_data = rd_id ? id_m[rd_addr[ID_AW-1:0]] : main_m[rd_addr];

endmodule

// File: rtl/nvm_read_port.sv
`timescale 1ns/1ps
module nvm_read_port #(
  parameter int DATA_W = 8
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              busy,
  input  logic              pend_msb,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);

  logic [DATA_W-1:0] poll_word;

  assign poll_word = {~pend_msb, {(DATA_W-1){1'b0}}};
  assign data_oe   = !ce_n && !oe_n && we_n;

  always_comb begin
    if (!data_oe)  data_out = '0;
    else if (busy) data_out = poll_word;
    else           data_out = arr_data;
  end

endmodule

// File: rtl/nvm_byte_core.sv
`timescale 1ns/1ps
module nvm_byte_core
  import nvm_core_pkg::*;
#(
  parameter int          ADDR_W      = 11,
  parameter int          DATA_W      = 8,
  parameter int          ID_DEPTH    = 32,
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned WRITE_US    = 1000,
  parameter int unsigned POR_US      = 5000,
  parameter int unsigned ERASE_US    = 10000,
  parameter bit          FAST_SIM    = 1'b0,
  parameter int unsigned FAST_WR_CYC = 16,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic              ready,
  input  logic              supply_good,
  input  logic              erase_hv,
  input  logic              a9_hv
);

  localparam int unsigned WR_CYC    = FAST_SIM ? FAST_WR_CYC : us_to_cyc(CLK_HZ, WRITE_US);
  localparam int unsigned POR_CYC   = us_to_cyc(CLK_HZ, POR_US);
  localparam int unsigned ERASE_CYC = us_to_cyc(CLK_HZ, ERASE_US);
  localparam int ID_AW  = $clog2(ID_DEPTH);
  localparam int BUN_W  = 5 + ADDR_W + DATA_W;
  localparam logic [BUN_W-1:0] BUN_RST = {2'b00, 3'b111, {(ADDR_W + DATA_W){1'b0}}};

  logic [BUN_W-1:0]  bun_raw, bun_s;
  logic              a9_s, er_s, ce_s, oe_s, we_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;

  logic              busy, cm_en, cm_id, clr_main, pend_msb, rd_id;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data, arr_data;

  assign bun_raw = {a9_hv, erase_hv, ce_n, oe_n, we_n, addr, data_in};

  nvm_strobe_sync #(
    .W      (BUN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (bun_raw),
    .q    (bun_s)
  );

  assign {a9_s, er_s, ce_s, oe_s, we_s, addr_s, din_s} = bun_s;

  nvm_write_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ID_DEPTH (ID_DEPTH),
    .WR_CYC   (WR_CYC),
    .POR_CYC  (POR_CYC),
    .ERASE_CYC(ERASE_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_s       (ce_s),
    .oe_s       (oe_s),
    .we_s       (we_s),
    .er_hv_s    (er_s),
    .a9_hv_s    (a9_s),
    .addr_s     (addr_s),
    .din_s      (din_s),
    .supply_good(supply_good),
    .busy       (busy),
    .cm_en      (cm_en),
    .cm_id      (cm_id),
    .cm_addr    (cm_addr),
    .cm_data    (cm_data),
    .clr_main   (clr_main),
    .pend_msb   (pend_msb)
  );

  assign rd_id = a9_hv && (&addr[ADDR_W-1:ID_AW]);

  nvm_cell_array #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ID_DEPTH(ID_DEPTH)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cm_en),
    .wr_id   (cm_id),
    .wr_addr (cm_addr),
    .wr_data (cm_data),
    .clr_main(clr_main),
    .rd_addr (addr),
    .rd_id   (rd_id),
    .rd_data (arr_data)
  );

  nvm_read_port #(
    .DATA_W(DATA_W)
  ) u_rport (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .busy    (busy),
    .pend_msb(pend_msb),
    .arr_data(arr_data),
    .data_out(data_out),
    .data_oe (data_oe)
  );

  assign ready = !busy;

endmodule

// File: rtl/nvm_byte_core_chk.sv
`timescale 1ns/1ps
module nvm_byte_core_chk
  import nvm_core_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned WRITE_US    = 1000,
  parameter int unsigned POR_US      = 5000,
  parameter bit          FAST_SIM    = 1'b0,
  parameter int unsigned FAST_WR_CYC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] data_out,
  input logic              data_oe,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              ready,
  input logic              supply_good
);

  localparam int unsigned WR_CYC  = FAST_SIM ? FAST_WR_CYC : us_to_cyc(CLK_HZ, WRITE_US);
  localparam int unsigned POR_CYC = us_to_cyc(CLK_HZ, POR_US);

  int unsigned low_run;
  int unsigned good_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= 0;
      good_run <= 0;
    end else begin
      low_run <= ready ? 0 : low_run + 1;
      if (!supply_good)            good_run <= 0;
      else if (good_run < POR_CYC) good_run <= good_run + 1;
    end
  end

  AST_READ_GATING: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> (!data_oe && data_out == '0)); // R1

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (low_run == WR_CYC)); // R3

  AST_POLL_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && data_oe) |-> (data_out[DATA_W-2:0] == '0)); // R4

  AST_SUPPLY_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(supply_good)); // R5

  AST_POR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> (good_run >= POR_CYC)); // R6

endmodule

bind nvm_byte_core nvm_byte_core_chk #(
  .DATA_W     (DATA_W),
  .CLK_HZ     (CLK_HZ),
  .WRITE_US   (WRITE_US),
  .POR_US     (POR_US),
  .FAST_SIM   (FAST_SIM),
  .FAST_WR_CYC(FAST_WR_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_out   (data_out),
  .data_oe    (data_oe),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .we_n       (we_n),
  .ready      (ready),
  .supply_good(supply_good)
);

// File: tb/nvm_byte_core_tb.sv
`timescale 1ns/1ps
module nvm_byte_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WR_CYC     = 16;

  logic        clk, rst_n;
  logic [10:0] addr;
  logic [7:0]  data_in, data_out;
  logic        data_oe, ce_n, oe_n, we_n, ready;
  logic        supply_good, erase_hv, a9_hv;

  nvm_byte_core #(
    .CLK_HZ     (1_000_000),
    .POR_US     (200),
    .ERASE_US   (300),
    .FAST_SIM   (1'b1),
    .FAST_WR_CYC(WR_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .ready(ready), .supply_good(supply_good),
    .erase_hv(erase_hv), .a9_hv(a9_hv)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int low_cnt = 0;

  always @(negedge clk) if (ready === 1'b0) low_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard: driver pushes expectations, monitor pops on each read strobe
  logic [8:0] exp_q[$];
  string      tag_q[$];
  event       rd_evt;

  initial begin
    forever begin
      @(rd_evt);
      begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({data_oe, data_out} == e, t, {data_oe, data_out}, e);
      end
    end
  end

  task automatic rd(input logic [10:0] a, input bit a9, input bit wev,
                    input logic [7:0] e, input bit eoe, input string tag);
    @(negedge clk);
    addr = a; a9_hv = a9; we_n = wev; ce_n = 1'b0; oe_n = 1'b0;
    #1;
    exp_q.push_back({eoe, e});
    tag_q.push_back(tag);
    -> rd_evt;
    #1;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; a9_hv = 1'b0;
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d,
                    input bit a9, input bit oev);
    @(negedge clk);
    addr = a; data_in = d; a9_hv = a9; oe_n = oev; ce_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    a9_hv = 1'b0;
  endtask

  task automatic wait_rdy();
    while (ready !== 1'b1) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; addr = '0; data_in = '0;
    supply_good = 0; erase_hv = 0; a9_hv = 0;
    repeat (5) @(negedge clk);
    chk(ready === 1'b1, "R10 ready in reset", ready, 1);
    chk(data_oe === 1'b0, "R1 idle not driven", data_oe, 0);
    rst_n = 1; supply_good = 1;

    // R6: write inside power-on window is blocked
    base = low_cnt;
    wr(11'h050, 8'h12, 0, 1);
    repeat (20) @(negedge clk);
    chk(low_cnt == base, "R6 no busy before POR", low_cnt - base, 0);
    repeat (250) @(negedge clk);
    rd(11'h050, 0, 1, 8'hFF, 1, "R6/R10 blocked byte still erased");

    // R3/R4: normal write, polling, busy length
    base = low_cnt;
    wr(11'h123, 8'h5A, 0, 1);
    chk(ready === 1'b0, "R3 busy after strobe", ready, 0);
    rd(11'h123, 0, 1, 8'h80, 1, "R4 poll inverted bit7");
    wait_rdy();
    chk(low_cnt - base == WR_CYC, "R3 busy length", low_cnt - base, WR_CYC);
    rd(11'h123, 0, 1, 8'h5A, 1, "R3 byte stored");

    // R4: read held open across the commit edge
    wr(11'h7FF, 8'hC3, 0, 1);
    @(negedge clk);
    addr = 11'h7FF; ce_n = 0; oe_n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ready === 1'b0) begin
        chk(data_oe && data_out == 8'h00, "R4 poll during busy", data_out, 8'h00);
      end else begin
        chk(data_oe && data_out == 8'hC3, "R4 true data at release", data_out, 8'hC3);
        break;
      end
    end
    ce_n = 1; oe_n = 1;

    // R7: second write inside busy window ignored
    wr(11'h200, 8'h33, 0, 1);
    wr(11'h201, 8'h44, 0, 1);
    wait_rdy();
    repeat (5) @(negedge clk);
    rd(11'h200, 0, 1, 8'h33, 1, "R7 first write kept");
    rd(11'h201, 0, 1, 8'hFF, 1, "R7 strobe while busy ignored");

    // R5: output enable low inhibits
    base = low_cnt;
    wr(11'h202, 8'h55, 0, 0);
    repeat (20) @(negedge clk);
    chk(low_cnt == base, "R5 oe low no busy", low_cnt - base, 0);
    rd(11'h202, 0, 1, 8'hFF, 1, "R5 oe low no store");

    // R5/R6: supply loss and restart of power-on window
    supply_good = 0;
    repeat (3) @(negedge clk);
    base = low_cnt;
    wr(11'h203, 8'h66, 0, 1);
    repeat (20) @(negedge clk);
    chk(low_cnt == base, "R5 supply low no busy", low_cnt - base, 0);
    rd(11'h203, 0, 1, 8'hFF, 1, "R5 supply low no store");
    supply_good = 1;
    repeat (50) @(negedge clk);
    base = low_cnt;
    wr(11'h203, 8'h66, 0, 1);
    repeat (20) @(negedge clk);
    chk(low_cnt == base, "R6 POR restarted", low_cnt - base, 0);
    repeat (250) @(negedge clk);
    wr(11'h203, 8'h66, 0, 1);
    wait_rdy();
    rd(11'h203, 0, 1, 8'h66, 1, "R6 write after POR");

    // R8: identification area
    wr(11'h7E5, 8'h11, 1, 1);
    wait_rdy();
    rd(11'h7E5, 0, 1, 8'hFF, 1, "R8 main untouched");
    rd(11'h7E5, 1, 1, 8'h11, 1, "R8 id byte");
    rd(11'h7FF, 1, 1, 8'hFF, 1, "R8 id separate from main");

    // R2: chip-enable framed write, address at last fall, data at first rise
    @(negedge clk);
    oe_n = 1; we_n = 0; addr = 11'h0AA; data_in = 8'hEE;
    repeat (4) @(negedge clk);
    addr = 11'h0AB;
    repeat (4) @(negedge clk);
    ce_n = 0;
    repeat (4) @(negedge clk);
    data_in = 8'h3C;
    repeat (4) @(negedge clk);
    ce_n = 1;
    repeat (4) @(negedge clk);
    data_in = 8'hEE;
    repeat (4) @(negedge clk);
    we_n = 1;
    wait_rdy();
    rd(11'h0AB, 0, 1, 8'h3C, 1, "R2 addr and data capture");
    rd(11'h0AA, 0, 1, 8'hFF, 1, "R2 early addr unused");

    // R1: drive gating
    rd(11'h0AB, 0, 0, 8'h00, 0, "R1 we low not driven");

    // R9: erase pulses
    base = low_cnt;
    @(negedge clk); erase_hv = 1;
    repeat (3) @(negedge clk);
    ce_n = 0; oe_n = 1; we_n = 0;
    repeat (100) @(negedge clk);
    we_n = 1;
    repeat (5) @(negedge clk);
    ce_n = 1;
    repeat (5) @(negedge clk);
    erase_hv = 0;
    repeat (5) @(negedge clk);
    rd(11'h123, 0, 1, 8'h5A, 1, "R9 short pulse no erase");
    @(negedge clk); erase_hv = 1;
    repeat (3) @(negedge clk);
    ce_n = 0; we_n = 0;
    repeat (320) @(negedge clk);
    we_n = 1;
    repeat (5) @(negedge clk);
    ce_n = 1;
    repeat (5) @(negedge clk);
    erase_hv = 0;
    repeat (5) @(negedge clk);
    chk(low_cnt == base, "R9 no write during erase", low_cnt - base, 0);
    rd(11'h123, 0, 1, 8'hFF, 1, "R9 main erased");
    rd(11'h7FF, 0, 1, 8'hFF, 1, "R9 top byte erased");
    rd(11'h7E5, 1, 1, 8'h11, 1, "R9 id kept");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule